// File: doc/BRIEF.md
# Receive Frame Length Checker with VLAN Allowance

The block watches received Ethernet frames on a 64-bit streaming receive path. It counts the bytes of each frame, FCS included, and works out from the type fields whether the frame carries no VLAN tag, one tag or two stacked tags. On the last beat of the frame it compares the length against a fixed 64-byte minimum and against a per-frame maximum. It then raises an undersize or oversize flag in a receive error vector.

The maximum comes from a 16-bit programmed value that is sampled when the frame starts. When the tag-inclusive control input is low, one tag widens the limit by 4 bytes and two stacked tags widen it by 8 bytes. When that input is high, the programmed value already covers any tags and is used as it stands. The block only observes the stream. It is placed beside the receive datapath, and its error vector is merged with the other receive error sources.

Top module: `rxl_len_chk`

## Requirements
- R1: Byte 0 of a frame is on data_i[63:56] of the start beat, and later bytes follow in descending lane order. On the end beat, empty_i gives the number of unused low-order byte lanes. On that beat len_o equals 8 times the number of beats in the frame minus empty_i.
- R2: A frame is classified as single-tagged (tag_o = 1) when bytes 12 and 13 hold 0x81 and 0x00.
- R3: A frame is classified as stacked (tag_o = 2) when bytes 12 and 13 hold 0x88A8 or 0x8100 and bytes 16 and 17 hold 0x8100. Stacked takes precedence over single. Any other frame reports tag_o = 0.
- R4: A frame too short to contain byte 13 is reported as untagged. A frame too short to contain byte 17 cannot be reported as stacked.
- R5: err_o[2] is set on the end beat when the frame length is below 64 bytes.
- R6: err_o[3] is set on the end beat when the length exceeds the limit. For an untagged frame the limit is the programmed maximum.
- R7: With vlan_incl_i low, the limit is the programmed maximum plus 4 for a single-tagged frame and plus 8 for a stacked frame.
- R8: With vlan_incl_i high, tagged and stacked frames use the programmed maximum with no allowance.
- R9: max_len_i is sampled on the start beat. A change to it on later beats of the same frame has no effect on that frame.
- R10: err_o, len_o and tag_o are zero on every cycle that is not a valid end beat of an open frame. Bits of err_o other than 2 and 3 are always zero.
- R11: Reset discards any frame in progress. Valid beats that arrive with no frame open and without sop_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Beat valid |
| sop_i | input | 1 | First beat of frame |
| eop_i | input | 1 | Last beat of frame |
| empty_i | input | 3 | Unused low-order byte lanes on the end beat |
| data_i | input | 64 | Frame bytes, byte 0 in the top lane |
| max_len_i | input | 16 | Programmed maximum frame length |
| vlan_incl_i | input | 1 | 1: programmed maximum already covers tags |
| err_o | output | 6 | Receive error vector: bit 2 undersize, bit 3 oversize |
| len_o | output | 17 | Frame length in bytes on the end beat |
| tag_o | output | 2 | 0 untagged, 1 single tag, 2 stacked tags |

## Verification
Every length from 1 to 96 bytes is swept for five header patterns: plain type, a single 0x8100 tag, 0x88A8/0x8100, 0x8100/0x8100, and 0x88A8 with no inner tag. The sweep is repeated for two programmed maxima and for both settings of the tag-inclusive control. Together these separate the 63/64 undersize edge, each of the three oversize edges, a tag that the frame length cuts off, and an outer tag that is wrongly treated as stacked. Some frames carry idle gaps or change the maximum after the start beat, which exposes any state lost across a gap or sampled at the wrong time. A reset in the middle of a frame is followed by an orphan end beat, which shows whether reset discards the stale frame.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_ONE  = 2'd1,
    TAG_TWO  = 2'd2
  } tag_e;

  localparam logic [15:0] TPID_C = 16'h8100;
  localparam logic [15:0] TPID_S = 16'h88A8;
  localparam int unsigned MIN_LEN = 64;
  localparam int unsigned BIT_UNDER = 2;
  localparam int unsigned BIT_OVER  = 3;
endpackage

// File: rtl/rxl_beat_ctr.sv
module rxl_beat_ctr #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned BEAT_W = LEN_W - 2,
  parameter int unsigned LENX_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [2:0]        empty_i,
  output logic              active_o,
  output logic [BEAT_W-1:0] idx_o,
  output logic [LENX_W-1:0] len_o
);
  localparam logic [BEAT_W-1:0] IDX_CAP = {{(BEAT_W-1){1'b1}}, 1'b0};

  logic              in_frame_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] idx_cur;

  assign active_o = valid_i && (sop_i || in_frame_q);
  assign idx_cur  = sop_i ? '0 : beat_q;
  assign idx_o    = idx_cur;
  assign len_o    = ({idx_cur, 3'b000} + LENX_W'(8)) - LENX_W'(empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      beat_q     <= '0;
    end else if (active_o) begin
      if (eop_i) begin
        in_frame_q <= 1'b0;
        beat_q     <= '0;
      end else begin
        in_frame_q <= 1'b1;
        beat_q     <= (idx_cur >= IDX_CAP) ? IDX_CAP : idx_cur + 1'b1;
      end
    end
  end

  // R1: index advances by one per accepted mid-frame beat
  assert_beat_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !eop_i && idx_cur < IDX_CAP) |=> (beat_q == $past(idx_cur) + 1'b1));

  // R11: a frame closes after its end beat
  assert_close_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && eop_i) |=> (!in_frame_q && beat_q == '0));
endmodule

// File: rtl/rxl_tag_det.sv
module rxl_tag_det
  import rxl_pkg::*;
#(
  parameter int unsigned BEAT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              eop_i,
  input  logic [2:0]        empty_i,
  input  logic [63:0]       data_i,
  input  logic [BEAT_W-1:0] idx_i,
  output tag_e              tag_o
);
  logic one_q, svc_q, two_q;
  logic [15:0] outer, inner;
  logic outer_ok, inner_ok;
  logic is_one_now, is_two_now;

  // bytes 12..13 sit in lanes 4..5 of beat 1; bytes 16..17 in lanes 0..1 of beat 2
  assign outer    = data_i[31:16];
  assign inner    = data_i[63:48];
  assign outer_ok = !eop_i || (empty_i <= 3'd2);
  assign inner_ok = !eop_i || (empty_i <= 3'd6);

  assign is_one_now = outer_ok && (outer == TPID_C);
  assign is_two_now = svc_q && inner_ok && (inner == TPID_C);

  always_comb begin
    tag_o = TAG_NONE;
    if (idx_i == BEAT_W'(1)) begin
      if (is_one_now) tag_o = TAG_ONE;
    end else if (idx_i == BEAT_W'(2)) begin
      if (is_two_now)  tag_o = TAG_TWO;
      else if (one_q)  tag_o = TAG_ONE;
    end else if (idx_i > BEAT_W'(2)) begin
      if (two_q)       tag_o = TAG_TWO;
      else if (one_q)  tag_o = TAG_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      one_q <= 1'b0;
      svc_q <= 1'b0;
      two_q <= 1'b0;
    end else if (active_i) begin
      if (idx_i == '0) begin
        one_q <= 1'b0;
        svc_q <= 1'b0;
        two_q <= 1'b0;
      end else if (idx_i == BEAT_W'(1)) begin
        one_q <= is_one_now;
        svc_q <= outer_ok && (outer == TPID_C || outer == TPID_S);
      end else if (idx_i == BEAT_W'(2)) begin
        two_q <= is_two_now;
      end
    end
  end

  // R3/R4: stacked needs at least three beats, single at least two
  assert_two_depth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tag_o == TAG_TWO) |-> (idx_i >= BEAT_W'(2)));
  assert_one_depth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tag_o == TAG_ONE) |-> (idx_i >= BEAT_W'(1)));
endmodule

// File: rtl/rxl_limit.sv
module rxl_limit
  import rxl_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LENX_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sop_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              vlan_incl_i,
  input  tag_e              tag_i,
  input  logic [LENX_W-1:0] len_i,
  output logic              under_o,
  output logic              over_o
);
  logic [LEN_W-1:0]  max_q;
  logic [LEN_W-1:0]  max_eff;
  logic [3:0]        add;
  logic [LENX_W-1:0] lim;

  assign max_eff = sop_i ? max_len_i : max_q;

  always_comb begin
    add = 4'd0;
    if (!vlan_incl_i) begin
      unique case (tag_i)
        TAG_ONE: add = 4'd4;
        TAG_TWO: add = 4'd8;
        default: add = 4'd0;
      endcase
    end
  end

  assign lim     = LENX_W'(max_eff) + LENX_W'(add);
  assign under_o = len_i < LENX_W'(MIN_LEN);
  assign over_o  = len_i > lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                max_q <= '0;
    else if (active_i && sop_i) max_q <= max_len_i;
  end

  // R8: tag-inclusive mode never widens the limit
  assert_incl_flat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlan_incl_i |-> (lim == LENX_W'(max_eff)));
  // R7: allowance is one of 0, 4 or 8 bytes above the maximum
  assert_allow_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim == LENX_W'(max_eff)) || (lim == LENX_W'(max_eff) + 4) || (lim == LENX_W'(max_eff) + 8));
  // R9: sampled maximum moves only on a start beat
  assert_max_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_i && sop_i) |=> (max_q == $past(max_q)));
endmodule

// File: rtl/rxl_len_chk.sv
module rxl_len_chk
  import rxl_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ERR_W  = 6,
  localparam int unsigned BEAT_W = LEN_W - 2,
  localparam int unsigned LENX_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [2:0]        empty_i,
  input  logic [63:0]       data_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              vlan_incl_i,
  output logic [ERR_W-1:0]  err_o,
  output logic [LENX_W-1:0] len_o,
  output logic [1:0]        tag_o
);
  logic              active;
  logic [BEAT_W-1:0] idx;
  logic [LENX_W-1:0] len;
  tag_e              tag;
  logic              under, over, fin;

  rxl_beat_ctr #(.LEN_W(LEN_W), .BEAT_W(BEAT_W), .LENX_W(LENX_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sop_i   (sop_i),
    .eop_i   (eop_i),
    .empty_i (empty_i),
    .active_o(active),
    .idx_o   (idx),
    .len_o   (len)
  );

  rxl_tag_det #(.BEAT_W(BEAT_W)) u_tag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .eop_i   (eop_i),
    .empty_i (empty_i),
    .data_i  (data_i),
    .idx_i   (idx),
    .tag_o   (tag)
  );

  rxl_limit #(.LEN_W(LEN_W), .LENX_W(LENX_W)) u_lim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .sop_i      (sop_i),
    .max_len_i  (max_len_i),
    .vlan_incl_i(vlan_incl_i),
    .tag_i      (tag),
    .len_i      (len),
    .under_o    (under),
    .over_o     (over)
  );

  assign fin = active && eop_i;

  always_comb begin
    err_o            = '0;
    err_o[BIT_UNDER] = fin && under;
    err_o[BIT_OVER]  = fin && over;
  end

  assign len_o = fin ? len : '0;
  assign tag_o = fin ? tag : TAG_NONE;

  // R10: outputs quiet away from an end beat
  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eop_i) |-> (err_o == '0 && len_o == '0 && tag_o == 2'd0));
  // R5: an undersize flag implies a length below 64
  assert_under_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[BIT_UNDER] |-> (len_o < LENX_W'(MIN_LEN)));
  // R6: an oversize flag implies a length above the programmed maximum
  assert_over_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[BIT_OVER] |-> (len_o > LENX_W'(sop_i ? max_len_i : u_lim.max_q)));
endmodule

// File: tb/rxl_len_chk_tb.sv
module rxl_len_chk_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sop_i = 1'b0, eop_i = 1'b0;
  logic [2:0]  empty_i = '0;
  logic [63:0] data_i = '0;
  logic [15:0] max_len_i = 16'd64;
  logic        vlan_incl_i = 1'b0;
  logic [5:0]  err_o;
  logic [16:0] len_o;
  logic [1:0]  tag_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxl_len_chk u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sop_i(sop_i), .eop_i(eop_i),
    .empty_i(empty_i), .data_i(data_i), .max_len_i(max_len_i), .vlan_incl_i(vlan_incl_i),
    .err_o(err_o), .len_o(len_o), .tag_o(tag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(err_o == 0, req, int'(err_o), 0);
    chk(len_o == 0, req, int'(len_o), 0);
    chk(tag_o == 0, req, int'(tag_o), 0);
  endtask

  function automatic logic [7:0] byte_at(input int k, input int kind);
    logic [15:0] o, i;
    o = 16'h0800; i = 16'h0800;
    case (kind)
      1: o = 16'h8100;
      2: begin o = 16'h88A8; i = 16'h8100; end
      3: begin o = 16'h8100; i = 16'h8100; end
      4: o = 16'h88A8;
      default: ;
    endcase
    case (k)
      12: return o[15:8];
      13: return o[7:0];
      16: return i[15:8];
      17: return i[7:0];
      default: return 8'(k * 3 + 1);
    endcase
  endfunction

  // kind: 0 plain, 1 single, 2 S+C, 3 C+C, 4 S only
  task automatic send_frame(input int len, input int kind, input int mx, input int mx_late,
                            input bit incl, input bit gaps);
    int nb, emp, exp_tag, lim;
    bit exp_u, exp_o;
    logic [15:0] o16, i16;
    nb  = (len + 7) / 8;
    emp = nb * 8 - len;
    o16 = {byte_at(12, kind), byte_at(13, kind)};
    i16 = {byte_at(16, kind), byte_at(17, kind)};
    exp_tag = 0;
    if (len >= 18 && (o16 == 16'h8100 || o16 == 16'h88A8) && i16 == 16'h8100) exp_tag = 2;
    else if (len >= 14 && o16 == 16'h8100) exp_tag = 1;
    lim = mx + (incl ? 0 : (exp_tag == 2 ? 8 : (exp_tag == 1 ? 4 : 0)));
    exp_u = len < 64;
    exp_o = len > lim;
    vlan_incl_i = incl;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      valid_i   = 1'b1;
      sop_i     = (b == 0);
      eop_i     = (b == nb - 1);
      empty_i   = eop_i ? 3'(emp) : 3'd0;
      max_len_i = (b == 0) ? 16'(mx) : 16'(mx_late);
      for (int l = 0; l < 8; l++) data_i[63-8*l -: 8] = byte_at(b * 8 + l, kind);
      #1;
      if (!eop_i) chk_quiet("R10 mid-frame");
      else begin
        chk(len_o == 17'(len), "R1 length", int'(len_o), len);
        chk(tag_o == 2'(exp_tag), (len < 18) ? "R4 short tag" : (kind >= 2 ? "R3 stacked" : "R2 single"),
            int'(tag_o), exp_tag);
        chk(err_o[2] == exp_u, "R5 undersize", int'(err_o[2]), int'(exp_u));
        chk(err_o[3] == exp_o, incl ? "R8 incl limit" : (exp_tag != 0 ? "R7 tag allowance" : "R6 oversize"),
            int'(err_o[3]), int'(exp_o));
        chk((err_o & 6'b110011) == 0, "R10 spare bits", int'(err_o), 0);
      end
      if (gaps && b != nb - 1) begin
        @(negedge clk);
        valid_i = 1'b0;
        #1 chk_quiet("R10 gap");
      end
    end
    @(negedge clk);
    valid_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk_quiet("R11 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    #1 chk_quiet("R10 idle");

    // main sweep
    for (int mi = 0; mi < 2; mi++)
      for (int inc = 0; inc < 2; inc++)
        for (int kind = 0; kind < 5; kind++)
          for (int len = 1; len <= 96; len++) begin
            int mx;
            mx = (mi == 0) ? 64 : 70;
            send_frame(len, kind, mx, mx, inc[0], (len % 5) == 0);
          end

    // R9: maximum changed after start beat
    send_frame(80, 0, 72, 100, 1'b0, 1'b0);
    send_frame(80, 1, 70, 40, 1'b0, 1'b1);
    send_frame(70, 0, 72, 60, 1'b0, 1'b0);
    send_frame(84, 3, 76, 90, 1'b0, 1'b0);

    // R11: orphan beats without a frame
    @(negedge clk);
    valid_i = 1'b1; sop_i = 1'b0; eop_i = 1'b1; empty_i = 3'd0; data_i = '1;
    #1 chk_quiet("R11 orphan eop");
    @(negedge clk); valid_i = 1'b0; eop_i = 1'b0;

    // R11: reset in mid-frame
    @(negedge clk);
    valid_i = 1'b1; sop_i = 1'b1; eop_i = 1'b0; data_i = '0;
    @(negedge clk);
    sop_i = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    valid_i = 1'b1; sop_i = 1'b0; eop_i = 1'b1; empty_i = 3'd0;
    #1 chk_quiet("R11 after reset");
    @(negedge clk); valid_i = 1'b0; eop_i = 1'b0;
    send_frame(68, 1, 64, 64, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule